// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit connects the load/store stage of a 32-bit RISC datapath to a word-wide, little-endian data memory port. For each request it adds a sign-extended 16-bit displacement to a base register value, which gives the byte address of the access. For stores it moves the byte, halfword or word of the source register onto the byte lanes that address selects and raises the matching byte enables. For loads it takes the addressed bytes out of the returned word and widens them to 32 bits, either by sign extension or by zero extension.

The memory port is treated as a single-cycle, word-wide interface. Read data is returned in the same cycle as the read strobe, against a word-aligned address. The unit registers the widened load value at the following clock edge. Any halfword or word access whose address does not meet its natural alignment is refused: no memory strobe is driven and a fault pulse appears on the next cycle. Caches, memory wait states and the register file lie outside the unit.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `base + offset` modulo 2^32, where the 16-bit offset is sign-extended first. `mem_addr` carries this address with bits [1:0] forced to 0, and bits [1:0] of the address select the byte lane.
- R2: A byte store (`req_size` = 2'b00) raises exactly one enable, `mem_be` = 1 << addr[1:0]. It places bits [7:0] of `store_data` on that lane of `mem_wdata`, and every other lane is zero.
- R3: A halfword store (`req_size` = 2'b01) raises `mem_be` = 4'b0011 when addr[1:0] = 00 and 4'b1100 when addr[1:0] = 10. It places bits [15:0] of `store_data` on those lanes.
- R4: A word store (`req_size` = 2'b10, and 2'b11 behaves the same) raises `mem_be` = 4'b1111 and drives `store_data` unchanged.
- R5: Loads are little-endian. The byte at address A is bits [8*A[1:0]+7 : 8*A[1:0]] of the memory word, and the halfword at A occupies bytes A and A+1, with A+1 the more significant.
- R6: Byte and halfword loads with `req_unsigned` = 0 replicate the top bit of the loaded value into the upper bits of `load_data`.
- R7: Byte and halfword loads with `req_unsigned` = 1 fill the upper bits of `load_data` with zeros. A word load returns the memory word unchanged.
- R8: A halfword request with addr[0] = 1, or a word request with addr[1:0] ≠ 00, is misaligned. In its cycle it drives neither `mem_wr_en` nor `mem_rd_en`, and `mem_be` is 0. `misalign_fault` is high in the next cycle only. Byte requests are never misaligned.
- R9: An aligned load raises `load_valid` for one cycle, one clock after the request, together with the new `load_data`. `load_data` then keeps its value through idle cycles, stores and misaligned requests until the next aligned load.
- R10: After reset `load_data` is 0 and `load_valid` and `misalign_fault` are low. With `req_valid` low, no memory strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A load or store request is present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend a narrow load instead of sign-extending it |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed byte displacement |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Memory word, valid in the cycle of `mem_rd_en` |
| load_data | output | 32 | Widened load result |
| load_valid | output | 1 | One-cycle pulse when `load_data` is updated |
| misalign_fault | output | 1 | One-cycle pulse after a misaligned request |

## Verification
The bench builds the unit with its default widths: a 32-bit data path, a 32-bit address and a 16-bit displacement. With these widths it can reach every byte lane of a word and both halfword positions. It can also reach negative displacements and an address sum that wraps past the top of the address space. The memory model is a small word array indexed by address bits [5:2]. That array is enough to show that a narrow store leaves its neighbouring lanes untouched and that a refused access leaves memory unchanged.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic [LANE_W-1:0] lane,
  output logic              misalign
);
  localparam int EXT_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] calc_ea(input logic [ADDR_W-1:0] b,
                                                input logic [OFF_W-1:0] o);
    return b + {{EXT_W{o[OFF_W-1]}}, o};
  endfunction

  function automatic logic bad_align(input acc_size_e s, input logic [LANE_W-1:0] l);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return l[0];
      default: return |l;
    endcase
  endfunction

  assign ea       = calc_ea(base, offset);
  assign lane     = ea[LANE_W-1:0];
  assign misalign = bad_align(size, lane);
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int LANE_W = $clog2(NB)
) (
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] src,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata
);
  function automatic logic [NB-1:0] size_mask(input acc_size_e s);
    case (s)
      SZ_BYTE: return NB'(1);
      SZ_HALF: return NB'(3);
      default: return {NB{1'b1}};
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] data_mask(input acc_size_e s);
    case (s)
      SZ_BYTE: return DATA_W'(8'hFF);
      SZ_HALF: return DATA_W'(16'hFFFF);
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  assign be    = size_mask(size) << lane;
  assign wdata = (src & data_mask(size)) << {lane, 3'b000};
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic              uns,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] load_data,
  output logic              load_valid
);
  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] w,
                                              input logic [LANE_W-1:0] l,
                                              input acc_size_e s,
                                              input logic u);
    logic [DATA_W-1:0] sh;
    sh = w >> {l, 3'b000};
    case (s)
      SZ_BYTE: return {{(DATA_W-8){sh[7] & ~u}}, sh[7:0]};
      SZ_HALF: return {{(DATA_W-16){sh[15] & ~u}}, sh[15:0]};
      default: return w;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_data  <= '0;
      load_valid <= 1'b0;
    end else begin
      load_valid <= fire;
      if (fire) load_data <= widen(rdata, lane, size, uns);
    end
  end

  // R9
  hold_between_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> $stable(load_data));
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] store_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_data,
  output logic              load_valid,
  output logic              misalign_fault
);
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);

  acc_size_e         size_w;
  logic [ADDR_W-1:0] ea_w;
  logic [LANE_W-1:0] lane_w;
  logic              misalign_w;
  logic              st_fire_w, ld_fire_w, bad_req_w;
  logic [NB-1:0]     be_w;

  assign size_w = acc_size_e'(req_size);

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_agen (
    .base(base), .offset(offset), .size(size_w),
    .ea(ea_w), .lane(lane_w), .misalign(misalign_w)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .NB(NB), .LANE_W(LANE_W)) u_steer (
    .size(size_w), .lane(lane_w), .src(store_data),
    .be(be_w), .wdata(mem_wdata)
  );

  assign bad_req_w = req_valid & misalign_w;
  assign st_fire_w = req_valid & req_store & ~misalign_w;
  assign ld_fire_w = req_valid & ~req_store & ~misalign_w;

  assign mem_addr  = {ea_w[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign mem_wr_en = st_fire_w;
  assign mem_rd_en = ld_fire_w;
  assign mem_be    = st_fire_w ? be_w : '0;

  lsu_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_extract (
    .clk(clk), .rst_n(rst_n), .fire(ld_fire_w), .size(size_w), .lane(lane_w),
    .uns(req_unsigned), .rdata(mem_rdata),
    .load_data(load_data), .load_valid(load_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) misalign_fault <= 1'b0;
    else        misalign_fault <= bad_req_w;
  end

  // R8
  misalign_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req_w |-> (!mem_wr_en && !mem_rd_en && mem_be == '0));

  // R8
  misalign_fault_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req_w |=> misalign_fault);

  // R8
  fault_only_after_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_req_w |=> !misalign_fault);

  // R9
  load_valid_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire_w |=> load_valid);

  // R2
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && size_w == SZ_BYTE) |-> $countones(mem_be) == 1);

  // R3
  half_two_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && size_w == SZ_HALF) |-> $countones(mem_be) == 2);

  // R4
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && (size_w == SZ_WORD || size_w == SZ_WIDE)) |-> mem_be == '1);

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_wr_en && !mem_rd_en));
endmodule

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = '0, store_data = '0;
  logic [15:0] offset = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
  logic        mem_wr_en, mem_rd_en, load_valid, misalign_fault;
  logic [3:0]  mem_be;

  logic [31:0] mem [16];
  int checks = 0, failures = 0;
  bit  done = 0;

  logic [31:0] c_addr, c_wd, c_ld;
  logic [3:0]  c_be;
  logic        c_we, c_re, c_lv, c_flt;

  always #5 clk = ~clk;

  lsu_lane_align u_lsu_lane_align (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base(base), .offset(offset),
    .store_data(store_data), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
    .mem_rd_en(mem_rd_en), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .load_data(load_data), .load_valid(load_valid),
    .misalign_fault(misalign_fault)
  );

  assign mem_rdata = mem[mem_addr[5:2]];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (mem_wr_en && mem_be[i]) mem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench-side model: pick bytes by lane explicitly, then widen.
  function automatic logic [31:0] ref_load(input logic [31:0] w, input logic [1:0] l,
                                           input logic [1:0] sz, input logic u);
    logic [7:0]  b;
    logic [15:0] h;
    case (l)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = l[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00) return (!u && b[7]) ? (32'hFFFFFF00 | b) : {24'h0, b};
    if (sz == 2'b01) return (!u && h[15]) ? (32'hFFFF0000 | h) : {16'h0, h};
    return w;
  endfunction

  task automatic req(input logic st, input logic [1:0] sz, input logic u,
                     input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = u;
    base = b; offset = o; store_data = d;
    #1;
    c_addr = mem_addr; c_be = mem_be; c_wd = mem_wdata; c_we = mem_wr_en; c_re = mem_rd_en;
    @(negedge clk);
    req_valid = 1'b0;
    c_lv = load_valid; c_ld = load_data; c_flt = misalign_fault;
  endtask

  task automatic t_reset;
    chk("R10 load_data", load_data, 32'h0);
    chk("R10 flags", {30'h0, load_valid, misalign_fault}, 32'h0);
    chk("R10 idle strobes", {30'h0, mem_wr_en, mem_rd_en}, 32'h0);
  endtask

  task automatic t_addr;
    req(1'b1, 2'b10, 1'b0, 32'h0000_0050, 16'hFFF0, 32'h807F_F122);
    chk("R1 negative offset", c_addr, 32'h0000_0040);
    chk("R4 word be", {28'h0, c_be}, 32'hF);
    chk("R4 word data", c_wd, 32'h807F_F122);
    req(1'b1, 2'b11, 1'b0, 32'hFFFF_FFF8, 16'h0010, 32'h1122_3344);
    chk("R1 wrap", c_addr, 32'h0000_0008);
    chk("R4 size 11 be", {28'h0, c_be}, 32'hF);
    req(1'b0, 2'b00, 1'b1, 32'h0000_0041, 16'h7FFF, 32'h0);
    chk("R1 positive offset", c_addr, 32'h0000_8040);
  endtask

  task automatic t_loads;
    for (int l = 0; l < 4; l++) begin
      req(1'b0, 2'b00, 1'b0, 32'h40, 16'(l), 32'h0);
      chk("R6 R5 signed byte", c_ld, ref_load(32'h807F_F122, 2'(l), 2'b00, 1'b0));
      chk("R9 valid after load", {31'h0, c_lv}, 32'h1);
      req(1'b0, 2'b00, 1'b1, 32'h40, 16'(l), 32'h0);
      chk("R7 R5 unsigned byte", c_ld, ref_load(32'h807F_F122, 2'(l), 2'b00, 1'b1));
    end
    for (int l = 0; l < 4; l += 2) begin
      req(1'b0, 2'b01, 1'b0, 32'h40, 16'(l), 32'h0);
      chk("R6 signed half", c_ld, ref_load(32'h807F_F122, 2'(l), 2'b01, 1'b0));
      req(1'b0, 2'b01, 1'b1, 32'h40, 16'(l), 32'h0);
      chk("R7 unsigned half", c_ld, ref_load(32'h807F_F122, 2'(l), 2'b01, 1'b1));
    end
    req(1'b0, 2'b10, 1'b1, 32'h40, 16'h0, 32'h0);
    chk("R7 word load", c_ld, 32'h807F_F122);
  endtask

  task automatic t_store_byte;
    req(1'b1, 2'b10, 1'b0, 32'h44, 16'h0, 32'h0);
    for (int l = 0; l < 4; l++) begin
      req(1'b1, 2'b00, 1'b0, 32'h44, 16'(l), 32'hAAAA_AA50 + l);
      chk("R2 byte be", {28'h0, c_be}, 32'(4'b0001 << l));
      chk("R2 byte data", c_wd, 32'(8'h50 + l) << (8 * l));
    end
    req(1'b0, 2'b10, 1'b0, 32'h44, 16'h0, 32'h0);
    chk("R2 byte merge", c_ld, 32'h5352_5150);
  endtask

  task automatic t_store_half;
    req(1'b1, 2'b01, 1'b0, 32'h4C, 16'h0, 32'h1234_BEEF);
    chk("R3 half be low", {28'h0, c_be}, 32'h3);
    chk("R3 half data low", c_wd, 32'h0000_BEEF);
    req(1'b1, 2'b01, 1'b0, 32'h4C, 16'h2, 32'h5678_CAFE);
    chk("R3 half be high", {28'h0, c_be}, 32'hC);
    chk("R3 half data high", c_wd, 32'hCAFE_0000);
    req(1'b0, 2'b10, 1'b0, 32'h4C, 16'h0, 32'h0);
    chk("R3 half merge", c_ld, 32'hCAFE_BEEF);
  endtask

  task automatic t_misalign;
    logic [31:0] prev;
    req(1'b1, 2'b10, 1'b0, 32'h50, 16'h0, 32'h0BAD_F00D);
    req(1'b0, 2'b10, 1'b0, 32'h50, 16'h0, 32'h0);
    prev = c_ld;
    req(1'b1, 2'b01, 1'b0, 32'h50, 16'h1, 32'hFFFF_FFFF);
    chk("R8 half store no strobe", {27'h0, c_we, c_re, 3'b000} | {28'h0, c_be}, 32'h0);
    chk("R8 fault after half", {31'h0, c_flt}, 32'h1);
    @(negedge clk);
    chk("R8 fault one cycle", {31'h0, misalign_fault}, 32'h0);
    req(1'b0, 2'b10, 1'b0, 32'h50, 16'h2, 32'h0);
    chk("R8 word load no read", {31'h0, c_re}, 32'h0);
    chk("R8 fault after word", {31'h0, c_flt}, 32'h1);
    chk("R9 no valid on fault", {31'h0, c_lv}, 32'h0);
    chk("R9 held over fault", c_ld, prev);
    req(1'b0, 2'b00, 1'b1, 32'h50, 16'h3, 32'h0);
    chk("R8 byte never faults", {31'h0, c_flt}, 32'h0);
    chk("R5 byte lane3", c_ld, 32'h0000_000B);
    req(1'b0, 2'b10, 1'b0, 32'h50, 16'h0, 32'h0);
    chk("R8 memory untouched", c_ld, 32'h0BAD_F00D);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    prev = load_data;
    @(negedge clk);
    chk("R9 valid one cycle", {31'h0, load_valid}, 32'h0);
    req(1'b1, 2'b10, 1'b0, 32'h54, 16'h0, 32'h1357_9BDF);
    chk("R9 held over store", c_ld, prev);
    repeat (3) @(negedge clk);
    chk("R9 held idle", load_data, prev);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_addr();
    t_loads();
    t_store_byte();
    t_store_half();
    t_misalign();
    t_hold();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end
endmodule